// File: doc/BRIEF.md
# Intermittent Fault Test Controller

This block runs a comparison test between a circuit under test and a trusted reference copy of the same sequential circuit. When started, it first holds a shared reset line low so that both units begin in a known state. It then sends the same input vector to both units, one vector per clock cycle, and compares their outputs in that cycle. Each unit's output depends on its current state and the vector it is given in the same cycle. A fault that shows up only now and then may corrupt internal state without causing an output error right away. The controller therefore keeps applying vectors until an output mismatch appears, or until enough matching steps have passed to accept the unit.

The controller stops at the first mismatch and reports the unit as faulty. It also reports the error latency, which is the number of vectors applied up to and including the one that gave the wrong output. If no mismatch appears, it stops after a programmed number of consecutive matching steps and reports a pass. Vectors come from one of two sources. The first is a fixed sequence computed at elaboration time. The second is a bank of per-bit pseudo-random generators, where each bit is 1 with a probability set by a threshold. The mode, the threshold and the pass count are captured at start, so the input distribution stays the same for the whole test.

Top module: `ift_ctrl`

## Requirements
- R1: After `start_i` is sampled high in idle, `unit_rst_no` is low for exactly RST_CYC (default 2) cycles starting the next cycle. No vector is valid while it is low. The first vector is valid in the cycle right after `unit_rst_no` returns high.
- R2: While the test runs, `vec_valid_o` is high in every cycle, one vector per cycle. `cut_out_i` and `ref_out_i` are compared in the same cycle as that vector.
- R3: When the outputs differ during a valid vector, the next cycle has `done_o` high and `faulty_o` high, and no further vector is made valid.
- R4: On a failure, `latency_o` equals the number of valid vectors applied, including the one that mismatched.
- R5: If every output matches, the test passes after exactly `pass_len_i` valid vectors. It then gives `done_o` high with `faulty_o` low and `latency_o` equal to that count.
- R6: If the captured pass count is zero, `done_o` rises in the cycle after the reset phase ends, with a pass and `latency_o` zero. No vector is applied.
- R7: In deterministic mode (`mode_i`=0), the k-th vector of a test (k from 0) is ((k mod 16)*37 + 17) mod 256.
- R8: In random mode (`mode_i`=1), vector bit b is 1 exactly when generator b's 16-bit value is less than or equal to the captured threshold. Generators never hold zero, so a threshold of 0 gives all-zero vectors and 16'hFFFF gives all-one vectors. A threshold of 16'h7FFF gives roughly half ones.
- R9: `mode_i`, `prob_thr_i` and `pass_len_i` are captured when the test starts. Changing them during a test does not affect the vectors or the verdict.
- R10: `done_o` is a one-cycle pulse. `faulty_o` and `latency_o` hold their values until the next start. `start_i` is ignored while a test is running.
- R11: While `rst_ni` is low, and afterwards until the first start, `done_o`, `faulty_o`, `vec_valid_o` and `latency_o` are zero and `unit_rst_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a test when the controller is idle |
| mode_i | input | 1 | 0 = deterministic sequence, 1 = pseudo-random vectors |
| prob_thr_i | input | 16 | Random-mode threshold that sets P(bit = 1) |
| pass_len_i | input | 16 | Number of consecutive matching steps needed to pass |
| cut_out_i | input | 8 | Output of the circuit under test |
| ref_out_i | input | 8 | Output of the reference unit |
| unit_rst_no | output | 1 | Shared active-low reset to both units |
| vec_valid_o | output | 1 | High when a vector is applied this cycle |
| vec_o | output | 8 | Input vector driven to both units |
| done_o | output | 1 | One-cycle end-of-test pulse |
| faulty_o | output | 1 | Verdict: 1 = mismatch seen |
| latency_o | output | 16 | Error latency, or the vector count on a pass |

## Verification
The bench injects two kinds of fault into a model of the unit under test. One kind flips the output only at a chosen step. The other corrupts the state only, so the mismatch shows up one step later. A controller that stopped on the fault step itself, or that counted latency from zero, would report a latency off by one. Faults placed on the last step before a pass, or just after it, check that the pass count is neither one short nor one long. A pass count of zero catches a controller that applies a stray vector. Changing the mode, threshold and pass count, and pulsing start, in the middle of a test catches a controller that does not latch its settings or that restarts while busy.

// File: rtl/ift_pkg.sv
package ift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST,
    ST_RUN,
    ST_DONE
  } ift_state_e;

  // deterministic sequence word for a given index
  function automatic logic [31:0] seq_word(input int unsigned idx);
    return 32'(idx * 32'd37 + 32'd17);
  endfunction

  // distinct, non-zero generator seed per vector bit
  function automatic logic [15:0] gen_seed(input int unsigned bit_idx);
    return (16'hACE1 + 16'(bit_idx * 32'h3C5)) | 16'h0001;
  endfunction
endpackage

// File: rtl/ift_lfsr.sv
module ift_lfsr #(
  parameter int unsigned       W    = 16,
  parameter logic [W-1:0]      TAPS = 16'hB400,
  parameter logic [W-1:0]      SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;

  // Galois form, shift toward lsb
  always_comb begin
    state_nxt = state_q >> 1;
    if (state_q[0]) state_nxt = state_nxt ^ TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (step_i) state_q <= state_nxt;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ift_rand_src.sv
module ift_rand_src #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned GEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [GEN_W-1:0] thr_i,
  output logic [VEC_W-1:0] vec_o
);
  import ift_pkg::*;

  logic [GEN_W-1:0] thr_q;

  // threshold frozen for the whole test
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     thr_q <= '0;
    else if (load_i) thr_q <= thr_i;
  end

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    logic [GEN_W-1:0] gen_val;

    ift_lfsr #(
      .W   (GEN_W),
      .TAPS(GEN_W'(16'hB400)),
      .SEED(GEN_W'(gen_seed(b)))
    ) u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .step_i (step_i),
      .state_o(gen_val)
    );

    assign vec_o[b] = (gen_val <= thr_q);
  end
endmodule

// File: rtl/ift_vec_rom.sv
module ift_vec_rom #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    addr_i,
  output logic [VEC_W-1:0] data_o
);
  import ift_pkg::*;

  logic [VEC_W-1:0] rom_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom_mem[g] = VEC_W'(seq_word(g));
  end

  assign data_o = rom_mem[addr_i];
endmodule

// File: rtl/ift_ctrl.sv
module ift_ctrl #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned LAT_W   = 16,
  parameter int unsigned GEN_W   = 16,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RST_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [GEN_W-1:0] prob_thr_i,
  input  logic [LAT_W-1:0] pass_len_i,
  input  logic [OUT_W-1:0] cut_out_i,
  input  logic [OUT_W-1:0] ref_out_i,
  output logic             unit_rst_no,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             done_o,
  output logic             faulty_o,
  output logic [LAT_W-1:0] latency_o
);
  import ift_pkg::*;

  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned RCW = $clog2(RST_CYC + 1);

  ift_state_e       state_q;
  logic [RCW-1:0]   rst_cnt_q;
  logic [LAT_W-1:0] step_q;
  logic [LAT_W-1:0] step_inc;
  logic [LAT_W-1:0] plen_q;
  logic             mode_q;
  logic             faulty_q;
  logic [LAT_W-1:0] lat_q;
  logic             arm;
  logic             running;
  logic             mismatch;
  logic [VEC_W-1:0] rom_vec;
  logic [VEC_W-1:0] rnd_vec;

  assign arm      = (state_q == ST_IDLE) && start_i;
  assign running  = (state_q == ST_RUN);
  assign mismatch = running && (cut_out_i != ref_out_i);
  assign step_inc = step_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rst_cnt_q <= '0;
      step_q    <= '0;
      plen_q    <= '0;
      mode_q    <= 1'b0;
      faulty_q  <= 1'b0;
      lat_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_RST;
            rst_cnt_q <= '0;
            mode_q    <= mode_i;
            plen_q    <= pass_len_i;
            faulty_q  <= 1'b0;
            lat_q     <= '0;
          end
        end
        ST_RST: begin
          if (rst_cnt_q == RCW'(RST_CYC - 1)) begin
            step_q  <= '0;
            state_q <= (plen_q == '0) ? ST_DONE : ST_RUN;
          end else begin
            rst_cnt_q <= rst_cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (mismatch) begin
            faulty_q <= 1'b1;
            lat_q    <= step_inc;
            state_q  <= ST_DONE;
          end else if (step_inc == plen_q) begin
            lat_q   <= plen_q;
            state_q <= ST_DONE;
          end else begin
            step_q <= step_inc;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ift_vec_rom #(
    .VEC_W(VEC_W),
    .DEPTH(DEPTH)
  ) u_rom (
    .addr_i(step_q[AW-1:0]),
    .data_o(rom_vec)
  );

  ift_rand_src #(
    .VEC_W(VEC_W),
    .GEN_W(GEN_W)
  ) u_rnd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(arm),
    .step_i(running),
    .thr_i (prob_thr_i),
    .vec_o (rnd_vec)
  );

  assign unit_rst_no = (state_q != ST_RST);
  assign vec_valid_o = running;
  assign vec_o       = mode_q ? rnd_vec : rom_vec;
  assign done_o      = (state_q == ST_DONE);
  assign faulty_o    = faulty_q;
  assign latency_o   = lat_q;
endmodule

// File: rtl/ift_ctrl_chk.sv
module ift_ctrl_chk #(
  parameter int unsigned OUT_W = 8,
  parameter int unsigned LAT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             unit_rst_no,
  input logic             vec_valid_o,
  input logic [OUT_W-1:0] cut_out_i,
  input logic [OUT_W-1:0] ref_out_i,
  input logic             done_o,
  input logic             faulty_o,
  input logic [LAT_W-1:0] latency_o
);
  AST_NO_VEC_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_rst_no |-> !vec_valid_o); // R1
  AST_RST_BEFORE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(!unit_rst_no)); // R1
  AST_STOP_ON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && (cut_out_i != ref_out_i)) |=> (done_o && faulty_o && !vec_valid_o)); // R3
  AST_MATCH_GOES_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && (cut_out_i == ref_out_i)) |=> (vec_valid_o || (done_o && !faulty_o))); // R5
  AST_FAIL_LAT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && faulty_o) |-> (latency_o != '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

bind ift_ctrl ift_ctrl_chk #(
  .OUT_W(OUT_W),
  .LAT_W(LAT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unit_rst_no(unit_rst_no),
  .vec_valid_o(vec_valid_o),
  .cut_out_i  (cut_out_i),
  .ref_out_i  (ref_out_i),
  .done_o     (done_o),
  .faulty_o   (faulty_o),
  .latency_o  (latency_o)
);

// File: tb/ift_ctrl_tb.sv
`timescale 1ns/1ps
module ift_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] prob_thr_i = '0;
  logic [15:0] pass_len_i = '0;
  logic [7:0]  cut_out_i;
  logic [7:0]  ref_out_i;
  logic        unit_rst_no;
  logic        vec_valid_o;
  logic [7:0]  vec_o;
  logic        done_o;
  logic        faulty_o;
  logic [15:0] latency_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // fault model: kind 0 none, 1 output flip at step, 2 state flip at step
  int          f_kind = 0;
  int          f_step = 0;
  logic [7:0]  ref_s, cut_s;
  int          bstep;
  int          ones_cnt;
  int          bits_cnt;

  always #2.5 clk_i = ~clk_i;

  ift_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .prob_thr_i(prob_thr_i), .pass_len_i(pass_len_i),
    .cut_out_i(cut_out_i), .ref_out_i(ref_out_i),
    .unit_rst_no(unit_rst_no), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
    .done_o(done_o), .faulty_o(faulty_o), .latency_o(latency_o)
  );

  always @(posedge clk_i) begin
    if (!unit_rst_no) begin
      ref_s <= '0; cut_s <= '0; bstep <= 0;
    end else if (vec_valid_o) begin
      ref_s <= {ref_s[6:0], ref_s[7]} ^ vec_o;
      cut_s <= ({cut_s[6:0], cut_s[7]} ^ vec_o) ^ ((f_kind == 2 && bstep == f_step) ? 8'h01 : 8'h00);
      bstep <= bstep + 1;
    end
  end
  assign ref_out_i = ref_s ^ vec_o;
  assign cut_out_i = cut_s ^ vec_o ^ ((f_kind == 1 && bstep == f_step) ? 8'h80 : 8'h00);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_seq(input int k);
    return 8'(((k % 16) * 37) + 17);
  endfunction

  always @(negedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // one complete test; poke disturbs settings and start mid-run
  task automatic run_one(input logic m, input logic [15:0] thr, input logic [15:0] plen,
                         input int kind, input int fs, input bit poke);
    int rlow = 0;
    int nvec = 0;
    int wait_c = 0;
    bit exp_f;
    int exp_l;
    bit vec_bad = 0;
    if (kind == 1 && fs < plen) begin exp_f = 1; exp_l = fs + 1; end
    else if (kind == 2 && fs + 1 < plen) begin exp_f = 1; exp_l = fs + 2; end
    else begin exp_f = 0; exp_l = plen; end
    f_kind = kind; f_step = fs;
    mode_i = m; prob_thr_i = thr; pass_len_i = plen;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!unit_rst_no && rlow < 10) begin
      if (vec_valid_o) vec_bad = 1;
      rlow++;
      @(negedge clk_i);
    end
    chk(rlow == 2 && !vec_bad, "R1 reset phase length", rlow, 2);
    if (plen != 0) chk(vec_valid_o == 1'b1, "R1 first vector after reset", int'(vec_valid_o), 1);
    while (!done_o && wait_c < 70000) begin
      chk(vec_valid_o == 1'b1, "R2 vector every run cycle", int'(vec_valid_o), 1);
      if (m == 1'b0)
        chk(vec_o == exp_seq(nvec), "R7 sequence word", int'(vec_o), int'(exp_seq(nvec)));
      else if (thr == 16'h0000)
        chk(vec_o == 8'h00, "R8 threshold zero", int'(vec_o), 0);
      else if (thr == 16'hFFFF)
        chk(vec_o == 8'hFF, "R8 threshold full", int'(vec_o), 255);
      else begin
        ones_cnt += $countones(vec_o); bits_cnt += 8;
      end
      nvec++;
      if (poke && nvec == 2) begin
        mode_i = ~m; prob_thr_i = ~thr; pass_len_i = 16'd1; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      wait_c++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R10 done seen", int'(done_o), 1);
    if (plen == 0) chk(nvec == 0, "R6 no vector for zero count", nvec, 0);
    chk(faulty_o == exp_f, exp_f ? "R3 verdict faulty" : "R5 verdict pass", int'(faulty_o), int'(exp_f));
    chk(latency_o == 16'(exp_l), exp_f ? "R4 latency" : "R5 pass count", int'(latency_o), exp_l);
    chk(nvec == exp_l, exp_f ? "R3 vectors stop at mismatch" : "R5 vectors applied", nvec, exp_l);
    if (poke) chk(faulty_o == exp_f && nvec == exp_l, "R9 settings latched", nvec, exp_l);
    @(negedge clk_i);
    chk(!done_o && !vec_valid_o, "R10 done one cycle", int'(done_o), 0);
    chk(faulty_o == exp_f && latency_o == 16'(exp_l), "R10 verdict held", int'(latency_o), exp_l);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd4242));
    ones_cnt = 0; bits_cnt = 0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !faulty_o && !vec_valid_o && latency_o == 0 && unit_rst_no,
        "R11 state in reset", int'(latency_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!done_o && !faulty_o && !vec_valid_o && latency_o == 0 && unit_rst_no,
        "R11 idle after reset", int'(done_o), 0);

    // directed corners
    run_one(1'b0, 16'h0, 16'd0, 0, 0, 0);        // R6
    run_one(1'b0, 16'h0, 16'd20, 0, 0, 0);       // R5 R7 wrap past 16
    run_one(1'b0, 16'h0, 16'd10, 1, 0, 0);       // R4 latency 1
    run_one(1'b0, 16'h0, 16'd10, 1, 9, 0);       // R3 fault on last step
    run_one(1'b0, 16'h0, 16'd10, 2, 8, 0);       // R4 delayed, last step
    run_one(1'b0, 16'h0, 16'd10, 2, 9, 0);       // R5 state fault too late
    run_one(1'b0, 16'h0, 16'd10, 1, 10, 0);      // R5 fault just after pass
    run_one(1'b1, 16'h0000, 16'd12, 0, 0, 0);    // R8 all zero
    run_one(1'b1, 16'hFFFF, 16'd12, 0, 0, 0);    // R8 all one
    run_one(1'b1, 16'h0000, 16'd15, 2, 6, 1);    // R9 R10 poke mid test
    run_one(1'b0, 16'h0, 16'd14, 1, 11, 1);      // R9 poke in sequence mode
    run_one(1'b1, 16'h7FFF, 16'd300, 0, 0, 0);   // R8 half distribution
    chk(ones_cnt * 100 > bits_cnt * 35 && ones_cnt * 100 < bits_cnt * 65,
        "R8 half distribution", ones_cnt, bits_cnt / 2);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic        m = 1'($urandom_range(0, 1));
      logic [15:0] pl = 16'($urandom_range(1, 40));
      int          kd = $urandom_range(0, 2);
      int          fs = $urandom_range(0, 45);
      logic [15:0] th = 16'($urandom);
      run_one(m, th, pl, kd, fs, 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule